// File: doc/BRIEF.md
# Bank Mapper with Latched Real-Time Clock

This block is the write-side control of a banked cartridge memory. A CPU writes a byte into one of several address regions; the block keeps the ROM bank seen in the switchable window, the RAM bank seen in the external RAM window, a global enable for that window, and whether the window shows RAM or one of five clock registers. The active clock register is chosen by the same select write that picks a RAM bank, and its byte is presented on `rtc_rd_data`.

Inside, a free-running time-of-day counter (seconds, minutes, hours and a 9-bit day count) advances on each pulse of `sec_tick`. Software never reads the running counter directly: writing 0 and then 1 into the latch region copies the running values into a set of snapshot registers, and reads always return that snapshot. The carry moduli are parameters. The defaults give a real clock, and a small setting makes day rollover and day overflow quick to reach.

Top module: `rtc_bank_mapper`

## Requirements
- R1: A write to region 0 (`wr_addr[15:13]` = 0) with data 0x0A sets `access_en`. Data 0x00 clears it. Any other data leaves it unchanged.
- R2: A write to region 1 sets `rom_bank` to `wr_data[6:0]`, except that a value of 0 gives bank 1.
- R3: A write to region 2 with data below 4 sets `ram_bank` to that value and clears `clk_mapped`.
- R4: A write to region 2 with data from 0x08 to 0x0C selects clock register (data minus 8) and sets `clk_mapped`. Other region-2 data (0x04 to 0x07, 0x0D to 0xFF) changes neither the selection nor the mapping.
- R5: A write of 1 to region 3 while not latched copies the running counters into the snapshot and enters the latched state. A write of 0 while latched leaves that state. Every other region-3 write is ignored.
- R6: `rtc_rd_data` always shows the snapshot of the selected register. Ticks that arrive after a latch do not change it.
- R7: Register 0 holds seconds modulo SEC_MOD (60 by default). Register 1 holds minutes modulo MIN_MOD (60). Register 2 holds hours modulo HR_MOD (24). Each wrap carries into the next field.
- R8: The day count is 9 bits wide. Register 3 holds bits 7:0, bit 0 of register 4 holds bit 8, and bits 6:1 of register 4 and unused high bits of registers 0 to 2 read as 0.
- R9: When the day count wraps from 511 to 0, bit 7 of register 4 becomes 1 and stays 1 until reset.
- R10: After reset, `rom_bank` is 1, `ram_bank` is 0, `access_en` and `clk_mapped` are 0, register 0 is selected, the block is not latched, and every clock register and running counter is 0.
- R11: Writes with `wr_addr[15]` = 1 (regions 4 to 7) change no output and do not latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address; bits 15:13 pick the region |
| wr_data | input | 8 | CPU write data |
| sec_tick | input | 1 | One-cycle pulse, one per elapsed second |
| rom_bank | output | ROM_BITS | Bank shown in the switchable ROM window |
| ram_bank | output | RAM_BITS | Bank shown in the external RAM window |
| access_en | output | 1 | External RAM or clock access enabled |
| clk_mapped | output | 1 | Window shows a clock register instead of RAM |
| rtc_rd_data | output | 8 | Snapshot byte of the selected clock register |

## Verification
Every control output is a register loaded on the clock edge that samples the write, so its new value is due one edge after the strobe. The bench drives each write on a falling edge, removes it on the next falling edge, and compares there. The read byte follows the selection and snapshot registers through a mux, so it is due on that same edge. A tick raised for n falling edges is counted on exactly n rising edges. The bench therefore keeps a running tick total, latches only while ticks are idle, and derives every expected field from that total with division and modulo on the moduli of the instance under test.

// File: rtl/rtcmap_pkg.sv
package rtcmap_pkg;
   localparam int DAY_BITS     = 9;
   localparam int NUM_CLK_REGS = 5;
   localparam int SEL_BITS     = 3;

   typedef enum logic [2:0] {
      RG_ACCESS = 3'd0,
      RG_ROMSEL = 3'd1,
      RG_MAPSEL = 3'd2,
      RG_LATCH  = 3'd3
   } region_e;

   localparam logic [7:0] KEY_ENABLE  = 8'h0A;
   localparam logic [7:0] KEY_DISABLE = 8'h00;
   localparam logic [7:0] CLK_SEL_LO  = 8'h08;
   localparam logic [7:0] CLK_SEL_HI  = 8'h0C;
endpackage

// File: rtl/rtcmap_ctrl.sv
module rtcmap_ctrl
   import rtcmap_pkg::*;
#(
   parameter int ROM_BITS = 7,
   parameter int RAM_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [15:0]         wr_addr,
   input  logic [7:0]          wr_data,
   output logic [ROM_BITS-1:0] rom_bank,
   output logic [RAM_BITS-1:0] ram_bank,
   output logic                access_en,
   output logic                clk_mapped,
   output logic [SEL_BITS-1:0] clk_sel,
   output logic                latch_pulse
);
   localparam int RAM_LIMIT = 1 << RAM_BITS;

   region_e              region;
   logic                 latched;
   logic [ROM_BITS-1:0]  rom_field;
   logic                 hit_access, hit_rom, hit_map, hit_latch;
   logic                 ram_pick, clk_pick;

   assign region     = region_e'(wr_addr[15:13]);
   assign rom_field  = wr_data[ROM_BITS-1:0];
   assign hit_access = wr_en && (region == RG_ACCESS);
   assign hit_rom    = wr_en && (region == RG_ROMSEL);
   assign hit_map    = wr_en && (region == RG_MAPSEL);
   assign hit_latch  = wr_en && (region == RG_LATCH);
   assign ram_pick   = hit_map && (int'(wr_data) < RAM_LIMIT);
   assign clk_pick   = hit_map && (wr_data >= CLK_SEL_LO) && (wr_data <= CLK_SEL_HI);

   assign latch_pulse = hit_latch && !latched && (wr_data == 8'h01);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_bank   <= ROM_BITS'(1);
         ram_bank   <= '0;
         access_en  <= 1'b0;
         clk_mapped <= 1'b0;
         clk_sel    <= '0;
         latched    <= 1'b0;
      end else begin
         if (hit_access) begin
            if (wr_data == KEY_ENABLE)       access_en <= 1'b1;
            else if (wr_data == KEY_DISABLE) access_en <= 1'b0;
         end
         if (hit_rom)
            rom_bank <= (rom_field == '0) ? ROM_BITS'(1) : rom_field;
         if (ram_pick) begin
            ram_bank   <= wr_data[RAM_BITS-1:0];
            clk_mapped <= 1'b0;
         end else if (clk_pick) begin
            clk_sel    <= SEL_BITS'(wr_data - CLK_SEL_LO);
            clk_mapped <= 1'b1;
         end
         if (latch_pulse)
            latched <= 1'b1;
         else if (hit_latch && latched && (wr_data == 8'h00))
            latched <= 1'b0;
      end
   end
endmodule

// File: rtl/rtcmap_modcnt.sv
module rtcmap_modcnt #(
   parameter int MOD = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   output logic [7:0] val,
   output logic       carry
);
   localparam int W = $clog2(MOD);

   logic [W-1:0] cnt;
   logic         at_top;

   assign at_top = (cnt == W'(MOD - 1));
   assign carry  = inc && at_top;
   assign val    = 8'(cnt);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc)
         cnt <= at_top ? '0 : cnt + W'(1);
   end
endmodule

// File: rtl/rtcmap_clock.sv
module rtcmap_clock
   import rtcmap_pkg::*;
#(
   parameter int SEC_MOD = 60,
   parameter int MIN_MOD = 60,
   parameter int HR_MOD  = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   output logic [7:0]          live_sec,
   output logic [7:0]          live_min,
   output logic [7:0]          live_hr,
   output logic [DAY_BITS-1:0] live_day,
   output logic                ovf
);
   localparam int STAGES = 3;

   logic [STAGES:0] cy;
   logic [7:0]      vals [STAGES];

   assign cy[0] = tick;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      localparam int MODV = (i == 0) ? SEC_MOD : (i == 1) ? MIN_MOD : HR_MOD;
      rtcmap_modcnt #(.MOD(MODV)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (cy[i]),
         .val   (vals[i]),
         .carry (cy[i+1])
      );
   end

   assign live_sec = vals[0];
   assign live_min = vals[1];
   assign live_hr  = vals[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_day <= '0;
         ovf      <= 1'b0;
      end else if (cy[STAGES]) begin
         live_day <= live_day + DAY_BITS'(1);
         if (&live_day) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/rtcmap_snap.sv
module rtcmap_snap
   import rtcmap_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [7:0]          live_sec,
   input  logic [7:0]          live_min,
   input  logic [7:0]          live_hr,
   input  logic [DAY_BITS-1:0] live_day,
   input  logic                ovf,
   input  logic [SEL_BITS-1:0] sel,
   output logic [7:0]          rd_data
);
   logic [7:0] snap [NUM_CLK_REGS];
   logic [7:0] fresh [NUM_CLK_REGS];

   assign fresh[0] = live_sec;
   assign fresh[1] = live_min;
   assign fresh[2] = live_hr;
   assign fresh[3] = live_day[7:0];
   assign fresh[4] = {ovf, 6'b0, live_day[8]};

   for (genvar k = 0; k < NUM_CLK_REGS; k++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)       snap[k] <= '0;
         else if (capture) snap[k] <= fresh[k];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_CLK_REGS; k++)
         if (sel == SEL_BITS'(k)) rd_data = snap[k];
   end
endmodule

// File: rtl/rtc_bank_mapper.sv
module rtc_bank_mapper
   import rtcmap_pkg::*;
#(
   parameter int ROM_BITS = 7,
   parameter int RAM_BITS = 2,
   parameter int SEC_MOD  = 60,
   parameter int MIN_MOD  = 60,
   parameter int HR_MOD   = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [15:0]         wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                sec_tick,
   output logic [ROM_BITS-1:0] rom_bank,
   output logic [RAM_BITS-1:0] ram_bank,
   output logic                access_en,
   output logic                clk_mapped,
   output logic [7:0]          rtc_rd_data
);
   if (ROM_BITS < 1 || ROM_BITS > 8) begin : g_bad_rom
      $error("ROM_BITS must be 1..8");
   end
   if (RAM_BITS < 1 || RAM_BITS > 3) begin : g_bad_ram
      $error("RAM_BITS must be 1..3 so RAM selects stay below clock selects");
   end
   if (SEC_MOD < 2 || SEC_MOD > 256 || MIN_MOD < 2 || MIN_MOD > 256 ||
       HR_MOD < 2 || HR_MOD > 256) begin : g_bad_mod
      $error("clock moduli must be 2..256");
   end

   logic [SEL_BITS-1:0] clk_sel;
   logic                latch_pulse;
   logic [7:0]          live_sec, live_min, live_hr;
   logic [DAY_BITS-1:0] live_day;
   logic                ovf;

   rtcmap_ctrl #(.ROM_BITS(ROM_BITS), .RAM_BITS(RAM_BITS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rom_bank    (rom_bank),
      .ram_bank    (ram_bank),
      .access_en   (access_en),
      .clk_mapped  (clk_mapped),
      .clk_sel     (clk_sel),
      .latch_pulse (latch_pulse)
   );

   rtcmap_clock #(.SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD)) u_clock (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sec_tick),
      .live_sec (live_sec),
      .live_min (live_min),
      .live_hr  (live_hr),
      .live_day (live_day),
      .ovf      (ovf)
   );

   rtcmap_snap u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (latch_pulse),
      .live_sec (live_sec),
      .live_min (live_min),
      .live_hr  (live_hr),
      .live_day (live_day),
      .ovf      (ovf),
      .sel      (clk_sel),
      .rd_data  (rtc_rd_data)
   );
endmodule

// File: rtl/rtcmap_chk.sv
module rtcmap_chk #(
   parameter int ROM_BITS = 7,
   parameter int RAM_BITS = 2,
   parameter int SEC_MOD  = 60
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [15:0]         wr_addr,
   input logic [7:0]          wr_data,
   input logic [ROM_BITS-1:0] rom_bank,
   input logic [RAM_BITS-1:0] ram_bank,
   input logic                access_en,
   input logic                clk_mapped,
   input logic [7:0]          rtc_rd_data,
   input logic [2:0]          clk_sel,
   input logic                latch_pulse,
   input logic [7:0]          live_sec,
   input logic                ovf
);
   a_r1_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'd0 && wr_data == 8'h0A) |=> access_en);

   a_r1_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'd0 && wr_data == 8'h00) |=> !access_en);

   a_r2_rom_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      rom_bank != '0);

   a_r3_ram_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'd2 && wr_data < 8'd4)
      |=> (!clk_mapped && ram_bank == $past(wr_data[RAM_BITS-1:0])));

   a_r4_clock_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'd2 && wr_data >= 8'h08 && wr_data <= 8'h0C)
      |=> clk_mapped);

   a_r5_latch_source: assert property (@(posedge clk) disable iff (!rst_n)
      latch_pulse |-> (wr_en && wr_addr[15:13] == 3'd3 && wr_data == 8'h01));

   a_r6_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_pulse |=> ($stable(clk_sel) -> $stable(rtc_rd_data)));

   a_r7_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(live_sec) < SEC_MOD);

   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   a_r11_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15]) |=> ($stable(rom_bank) && $stable(ram_bank) &&
                                  $stable(access_en) && $stable(clk_mapped)));
endmodule

bind rtc_bank_mapper rtcmap_chk #(
   .ROM_BITS (ROM_BITS),
   .RAM_BITS (RAM_BITS),
   .SEC_MOD  (SEC_MOD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .rom_bank    (rom_bank),
   .ram_bank    (ram_bank),
   .access_en   (access_en),
   .clk_mapped  (clk_mapped),
   .rtc_rd_data (rtc_rd_data),
   .clk_sel     (clk_sel),
   .latch_pulse (latch_pulse),
   .live_sec    (live_sec),
   .ovf         (ovf)
);

// File: tb/tb_rtc_bank_mapper.sv
module tb_rtc_bank_mapper;
   localparam int CLK_PERIOD = 10;
   localparam int SM = 2, MM = 2, HM = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        sec_tick = 1'b0;

   logic [6:0] d_rom, s_rom;
   logic [1:0] d_ram, s_ram;
   logic       d_acc, s_acc, d_map, s_map;
   logic [7:0] d_rd, s_rd;

   int    total = 0;
   int    bad = 0;
   longint tcount = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_bank_mapper dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sec_tick(sec_tick), .rom_bank(d_rom), .ram_bank(d_ram), .access_en(d_acc),
      .clk_mapped(d_map), .rtc_rd_data(d_rd));

   rtc_bank_mapper #(.SEC_MOD(SM), .MIN_MOD(MM), .HR_MOD(HM)) dut_small (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sec_tick(sec_tick), .rom_bank(s_rom), .ram_bank(s_ram), .access_en(s_acc),
      .clk_mapped(s_map), .rtc_rd_data(s_rd));

   task automatic chk(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         sec_tick = 1'b1;
         repeat (n) @(negedge clk);
         sec_tick = 1'b0;
         tcount += longint'(n);
      end
   endtask

   function automatic int exp_reg(input int sm, input int mm, input int hm,
                                  input int k, input longint t);
      longint days = t / longint'(sm * mm * hm);
      int d = int'(days % 512);
      case (k)
         0: return int'(t % sm);
         1: return int'((t / sm) % mm);
         2: return int'((t / (sm * mm)) % hm);
         3: return d & 8'hFF;
         default: return ((days >= 512) ? 128 : 0) | ((d >> 8) & 1);
      endcase
   endfunction

   task automatic check_all(input string req);
      wr(16'h6000, 8'h00);
      wr(16'h6000, 8'h01);
      for (int k = 0; k < 5; k++) begin
         wr(16'h4000, 8'(8 + k));
         chk(req, $sformatf("default reg%0d T=%0d", k, tcount), int'(d_rd), exp_reg(60, 60, 24, k, tcount));
         chk(req, $sformatf("small reg%0d T=%0d", k, tcount), int'(s_rd), exp_reg(SM, MM, HM, k, tcount));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 180000);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int exp_rom, exp_ram, exp_map, snap0;
      longint tl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", "rom_bank", int'(d_rom), 1);
      chk("R10", "ram_bank", int'(d_ram), 0);
      chk("R10", "access_en", int'(d_acc), 0);
      chk("R10", "clk_mapped", int'(d_map), 0);
      chk("R10", "rd_data", int'(d_rd), 0);
      chk("R10", "small rd_data", int'(s_rd), 0);

      // R1 access enable keys
      wr(16'h0000, 8'h0A); chk("R1", "enable", int'(d_acc), 1);
      wr(16'h1F00, 8'h05); chk("R1", "other kept 1", int'(d_acc), 1);
      wr(16'h0123, 8'h00); chk("R1", "disable", int'(d_acc), 0);
      wr(16'h0000, 8'h0B); chk("R1", "other kept 0", int'(d_acc), 0);
      wr(16'h0000, 8'h0A);

      // R2 ROM bank sweep
      for (int d = 0; d < 256; d++) begin
         wr(16'h2000 | 16'((d * 37) & 16'h1FFF), 8'(d));
         exp_rom = ((d & 127) == 0) ? 1 : (d & 127);
         chk("R2", $sformatf("rom d=%0d", d), int'(d_rom), exp_rom);
      end

      // R3 R4 select sweep
      exp_ram = 0; exp_map = 0;
      for (int d = 0; d < 256; d++) begin
         wr(16'h4000 | 16'((d * 53) & 16'h1FFF), 8'(d));
         if (d < 4) begin exp_ram = d; exp_map = 0; end
         else if (d >= 8 && d <= 12) exp_map = 1;
         chk("R3", $sformatf("ram d=%0d", d), int'(d_ram), exp_ram);
         chk("R4", $sformatf("map d=%0d", d), int'(s_map), exp_map);
      end

      // R5 R6 R7 first snapshot and hold
      ticks(3725);
      check_all("R7");
      wr(16'h4000, 8'h08);
      tl = tcount;
      ticks(7);
      chk("R6", "hold after ticks", int'(d_rd), exp_reg(60, 60, 24, 0, tl));
      wr(16'h6000, 8'h01);
      chk("R5", "1 while latched ignored", int'(d_rd), exp_reg(60, 60, 24, 0, tl));
      wr(16'h6000, 8'h02);
      wr(16'h6000, 8'h01);
      chk("R5", "2 does not unlatch", int'(d_rd), exp_reg(60, 60, 24, 0, tl));

      // R4 ignored select values keep selection
      wr(16'h4000, 8'h09);
      snap0 = exp_reg(60, 60, 24, 1, tl);
      wr(16'h4000, 8'h0D);
      chk("R4", "0x0D ignored rd", int'(d_rd), snap0);
      wr(16'h4000, 8'h06);
      chk("R4", "0x06 ignored rd", int'(d_rd), snap0);
      chk("R4", "0x06 ignored map", int'(d_map), 1);

      // R11 upper regions
      wr(16'h6000, 8'h00);
      wr(16'h4000, 8'h08);
      wr(16'h8000, 8'h00);
      wr(16'hA000, 8'h01);
      wr(16'hC000, 8'h03);
      wr(16'hE000, 8'h01);
      chk("R11", "rom", int'(d_rom), 127);
      chk("R11", "access", int'(d_acc), 1);
      chk("R11", "map", int'(d_map), 1);
      chk("R11", "no latch", int'(d_rd), exp_reg(60, 60, 24, 0, tl));
      wr(16'h4000, 8'h02);
      wr(16'hA000, 8'h01);
      chk("R11", "ram", int'(d_ram), 2);
      chk("R11", "map clear", int'(d_map), 0);

      // R5 relatch picks up new time
      check_all("R5");

      // R7 R8 R9 rollovers
      for (int s = 0; s < 7; s++) begin
         longint tgt;
         case (s)
            0: tgt = 4095; 1: tgt = 4096; 2: tgt = 4103; 3: tgt = 8200;
            4: tgt = 86399; 5: tgt = 86400; default: tgt = 86465;
         endcase
         ticks(int'(tgt - tcount));
         check_all((s < 3) ? "R9" : "R8");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule